// File: doc/BRIEF.md
# Adaptive Equaliser Sweep Sequencer

This block runs one adaptation pass for a receiver equaliser. It waits until the link is ready. That means signal present, the training-update flag clear if the start mode asks for it, an acceptable training pattern in use, and the pattern register read since the last rate change if that read is required. It then walks the equaliser setting upward from zero to a programmed ceiling. At each setting it first waits a programmable settling time for the equaliser DAC. It then counts mid-eye hits from an eye monitor over a programmable window.

The setting with the most hits wins. A signed offset (a 3-bit magnitude code plus a sign bit) is applied to the winner, and the sum is clamped to the legal equaliser range. The clamped value is reported as the result. A second mode measures only setting zero. In that mode the offset is not used.

The sequencer drives the equaliser setting and a "transmitter off" request. It also reports a done flag, a per-setting settle-complete flag and a sticky hit-counter overflow flag. Configuration inputs are expected to be held stable while a pass runs.

Top module: `aeq_sweep_seq`

## Requirements
- R1: With `cfg_start_sel`=0 a pass may start when `cfg_enable` and `sig_det` are both high. With `cfg_start_sel`=1, `train_flag` must also be low. Missing any of these keeps `done` high.
- R2: `cfg_pat_sel[0]`=0 admits training patterns 0, 5, 6, 7 and 8 on `pat_code`. `cfg_pat_sel[0]`=1 admits only 5, 6, 7 and 8. Any other code blocks the start.
- R3: With `cfg_pat_sel[1]`=0, a `rate_change` pulse blocks starting until a later `pat_read` pulse. A `rate_change` and a `pat_read` in the same cycle leave starting blocked. With `cfg_pat_sel[1]`=1 no read is needed. After reset no read is needed.
- R4: A pass visits settings 0 up to `cfg_upper` in order on `eq_setting`. Each setting spends `cfg_settle`+1 cycles settling with `settle_done` low, then `cfg_dwell`+1 cycles counting `hit_inc` with `settle_done` high.
- R5: Hits for each setting are counted in a 13-bit saturating counter. An increment while it is at 8191 sets `hit_ovf`. `hit_ovf` stays set until the next pass starts.
- R6: The winning setting is the one with the strictly largest hit count. On a tie the lower setting wins. If every count is zero, the winner is 0.
- R7: The result is the winner plus `cfg_ofs_code` when `cfg_ofs_neg`=0, or the winner plus (`cfg_ofs_code`−8) when `cfg_ofs_neg`=1. It is clamped to 0..15 and appears on `eq_result` when `done` rises.
- R8: With `cfg_zero_only`=1 only setting 0 is measured, the offset is ignored and `eq_result` becomes 0.
- R9: `done` is low while a pass runs and rises at its end. After a pass ends, no new pass starts until `cfg_enable` or `sig_det` has gone low.
- R10: `tx_off` is high throughout a pass exactly when `cfg_tx_hold` is 1, and low otherwise.
- R11: After reset `done`=1, `hit_ovf`=0, `eq_result`=0, `eq_setting`=0, `settle_done`=0 and `tx_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Adaptation allowed |
| cfg_start_sel | input | 1 | 1: also require training flag clear |
| cfg_pat_sel | input | 2 | bit0 strict pattern set, bit1 skip read-after-rate-change |
| cfg_upper | input | 4 | Highest setting swept |
| cfg_zero_only | input | 1 | Measure setting 0 only |
| cfg_ofs_code | input | 3 | Offset magnitude code |
| cfg_ofs_neg | input | 1 | Offset sign (1 = code−8) |
| cfg_tx_hold | input | 1 | Hold transmitter off during a pass |
| cfg_settle | input | 16 | Settling wait, cycles minus one |
| cfg_dwell | input | 16 | Counting window, cycles minus one |
| sig_det | input | 1 | Signal detected |
| train_flag | input | 1 | Training-update flag |
| pat_code | input | 4 | Current training pattern |
| rate_change | input | 1 | Rate change pulse |
| pat_read | input | 1 | Pattern register read pulse |
| hit_inc | input | 1 | Mid-eye hit increment |
| eq_setting | output | 4 | Equaliser setting under test |
| settle_done | output | 1 | Settling finished for current setting |
| tx_off | output | 1 | Transmitter disable request |
| done | output | 1 | No pass running |
| hit_ovf | output | 1 | Sticky hit-counter overflow |
| eq_result | output | 4 | Offset and clamped winning setting |

## Verification
Two of the start conditions can change in the same cycle: the read-after-rate-change arming and its clearing. A rate change clears the arming, and a pattern read restores it. The bench pulses `rate_change` and `pat_read` together with everything else ready and checks that `done` stays high, because the clear must win. A lone read afterwards must let the pass begin. The sweep results themselves are judged against winners and clamped offsets that the bench computes from hit profiles it drives against `eq_setting`.

// File: rtl/aeq_pkg.sv
package aeq_pkg;

    localparam int EQ_W   = 4;
    localparam int OFS_W  = 3;
    localparam int PAT_W  = 4;
    localparam int HIT_W  = 13;
    localparam int EQ_MAX = (1 << EQ_W) - 1;
    localparam int OFS_SPAN = 1 << OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COUNT  = 2'd2,
        ST_DONE   = 2'd3
    } aeq_state_e;

    function automatic logic pattern_ok(input logic [PAT_W-1:0] p, input logic strict);
        logic in_band;
        in_band = (p >= PAT_W'(5)) && (p <= PAT_W'(8));
        return in_band || (!strict && (p == '0));
    endfunction

    function automatic logic [EQ_W-1:0] apply_offset(input logic [EQ_W-1:0] best,
                                                     input logic [OFS_W-1:0] code,
                                                     input logic neg);
        int sum;
        sum = int'(best) + (neg ? (int'(code) - OFS_SPAN) : int'(code));
        if (sum < 0)
            return '0;
        if (sum > EQ_MAX)
            return EQ_W'(EQ_MAX);
        return EQ_W'(sum);
    endfunction

endpackage

// File: rtl/aeq_start_gate.sv
module aeq_start_gate
    import aeq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_start_sel,
    input  logic [1:0]       cfg_pat_sel,
    input  logic             sig_det,
    input  logic             train_flag,
    input  logic [PAT_W-1:0] pat_code,
    input  logic             rate_change,
    input  logic             pat_read,
    output logic             start_ok
);

    logic read_armed_q;

    // Rate change clears the arming and has priority over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            read_armed_q <= 1'b1;
        else if (rate_change)
            read_armed_q <= 1'b0;
        else if (pat_read)
            read_armed_q <= 1'b1;
    end

    logic link_ready;
    logic flag_ok;
    logic pat_ok;
    logic read_ok;

    always_comb begin
        link_ready = cfg_enable && sig_det;
        flag_ok    = !cfg_start_sel || !train_flag;
        pat_ok     = pattern_ok(pat_code, cfg_pat_sel[0]);
        read_ok    = cfg_pat_sel[1] || read_armed_q;
        start_ok   = link_ready && flag_ok && pat_ok && read_ok;
    end

    p_rate_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        rate_change |=> (!start_ok || cfg_pat_sel[1] || $past(pat_read) && !$past(rate_change)));

    p_flag_blocks_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_start_sel && train_flag) |-> !start_ok);

endmodule

// File: rtl/aeq_timer.sv
module aeq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    p_timer_steps_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_timer_loads_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/aeq_hit_counter.sv
module aeq_hit_counter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_cnt,
    input  logic         clr_ovf,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic [W-1:0] count_nxt,
    output logic         ovf
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;
    logic         ovf_q;
    logic         at_max;

    always_comb begin
        at_max    = (cnt_q == CNT_MAX);
        count_nxt = (inc && !at_max) ? cnt_q + 1'b1 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (clr_cnt)
                cnt_q <= '0;
            else
                cnt_q <= count_nxt;

            if (clr_ovf)
                ovf_q <= 1'b0;
            else if (inc && at_max && !clr_cnt)
                ovf_q <= 1'b1;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr_cnt && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_ovf) |=> ovf_q);

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(cnt_q) == CNT_MAX);

endmodule

// File: rtl/aeq_sweep_seq.sv
module aeq_sweep_seq
    import aeq_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int CNT_W = HIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_start_sel,
    input  logic [1:0]       cfg_pat_sel,
    input  logic [EQ_W-1:0]  cfg_upper,
    input  logic             cfg_zero_only,
    input  logic [OFS_W-1:0] cfg_ofs_code,
    input  logic             cfg_ofs_neg,
    input  logic             cfg_tx_hold,
    input  logic [TMR_W-1:0] cfg_settle,
    input  logic [TMR_W-1:0] cfg_dwell,
    input  logic             sig_det,
    input  logic             train_flag,
    input  logic [PAT_W-1:0] pat_code,
    input  logic             rate_change,
    input  logic             pat_read,
    input  logic             hit_inc,
    output logic [EQ_W-1:0]  eq_setting,
    output logic             settle_done,
    output logic             tx_off,
    output logic             done,
    output logic             hit_ovf,
    output logic [EQ_W-1:0]  eq_result
);

    logic start_ok;

    aeq_start_gate u_gate (
        .clk           (clk),
        .rst           (rst),
        .cfg_enable    (cfg_enable),
        .cfg_start_sel (cfg_start_sel),
        .cfg_pat_sel   (cfg_pat_sel),
        .sig_det       (sig_det),
        .train_flag    (train_flag),
        .pat_code      (pat_code),
        .rate_change   (rate_change),
        .pat_read      (pat_read),
        .start_ok      (start_ok)
    );

    aeq_state_e       st_q, st_d;
    logic [EQ_W-1:0]  eq_q, eq_d;
    logic [EQ_W-1:0]  best_eq_q, best_eq_d;
    logic [CNT_W-1:0] best_cnt_q, best_cnt_d;
    logic [EQ_W-1:0]  res_q, res_d;
    logic             sflag_q, sflag_d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cnt_clr;
    logic             ovf_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_now;
    logic [CNT_W-1:0] cnt_nxt;
    logic             take;
    logic             last;
    logic [EQ_W-1:0]  winner;

    aeq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    assign cnt_inc = hit_inc && (st_q == ST_COUNT);

    aeq_hit_counter #(.W(CNT_W)) u_hits (
        .clk       (clk),
        .rst       (rst),
        .clr_cnt   (cnt_clr),
        .clr_ovf   (ovf_clr),
        .inc       (cnt_inc),
        .count     (cnt_now),
        .count_nxt (cnt_nxt),
        .ovf       (hit_ovf)
    );

    always_comb begin
        st_d       = st_q;
        eq_d       = eq_q;
        best_eq_d  = best_eq_q;
        best_cnt_d = best_cnt_q;
        res_d      = res_q;
        sflag_d    = sflag_q;
        tmr_load   = 1'b0;
        tmr_val    = cfg_settle;
        cnt_clr    = 1'b0;
        ovf_clr    = 1'b0;
        take       = (cnt_nxt > best_cnt_q);
        last       = cfg_zero_only || (eq_q >= cfg_upper);
        winner     = take ? eq_q : best_eq_q;

        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) begin
                    st_d       = ST_SETTLE;
                    eq_d       = '0;
                    best_eq_d  = '0;
                    best_cnt_d = '0;
                    sflag_d    = 1'b0;
                    tmr_load   = 1'b1;
                    cnt_clr    = 1'b1;
                    ovf_clr    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    st_d     = ST_COUNT;
                    sflag_d  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_dwell;
                    cnt_clr  = 1'b1;
                end
            end
            ST_COUNT: begin
                if (tmr_zero) begin
                    if (take) begin
                        best_cnt_d = cnt_nxt;
                        best_eq_d  = eq_q;
                    end
                    if (last) begin
                        st_d  = ST_DONE;
                        res_d = cfg_zero_only ? '0
                              : apply_offset(winner, cfg_ofs_code, cfg_ofs_neg);
                    end else begin
                        st_d     = ST_SETTLE;
                        eq_d     = eq_q + 1'b1;
                        sflag_d  = 1'b0;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!(cfg_enable && sig_det))
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            eq_q       <= '0;
            best_eq_q  <= '0;
            best_cnt_q <= '0;
            res_q      <= '0;
            sflag_q    <= 1'b0;
        end else begin
            st_q       <= st_d;
            eq_q       <= eq_d;
            best_eq_q  <= best_eq_d;
            best_cnt_q <= best_cnt_d;
            res_q      <= res_d;
            sflag_q    <= sflag_d;
        end
    end

    logic running;
    assign running     = (st_q == ST_SETTLE) || (st_q == ST_COUNT);
    assign done        = !running;
    assign tx_off      = cfg_tx_hold && running;
    assign eq_setting  = eq_q;
    assign settle_done = sflag_q;
    assign eq_result   = res_q;

    p_start_gated_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(start_ok));

    p_step_order_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COUNT && tmr_zero && !cfg_zero_only && eq_q < cfg_upper)
        |=> (eq_q == $past(eq_q) + 1'b1) && !sflag_q);

    p_count_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COUNT) |-> sflag_q);

    p_best_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COUNT) |=> (best_cnt_q >= $past(best_cnt_q)) || (st_q == ST_SETTLE && eq_q == '0));

    p_zero_only_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_zero_only && running) |-> (eq_q == '0));

    p_done_end_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(st_q) == ST_COUNT);

    p_no_rerun_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && cfg_enable && sig_det) |=> done);

endmodule

// File: tb/aeq_sweep_seq_bench.sv
module aeq_sweep_seq_bench;
    import aeq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_enable = 1'b0;
    logic             cfg_start_sel = 1'b0;
    logic [1:0]       cfg_pat_sel = 2'b10;
    logic [3:0]       cfg_upper = 4'hF;
    logic             cfg_zero_only = 1'b0;
    logic [2:0]       cfg_ofs_code = 3'd0;
    logic             cfg_ofs_neg = 1'b0;
    logic             cfg_tx_hold = 1'b1;
    logic [15:0]      cfg_settle = 16'd3;
    logic [15:0]      cfg_dwell = 16'd15;
    logic             sig_det = 1'b1;
    logic             train_flag = 1'b0;
    logic [3:0]       pat_code = 4'd5;
    logic             rate_change = 1'b0;
    logic             pat_read = 1'b0;
    logic             hit_inc;
    logic [3:0]       eq_setting;
    logic             settle_done;
    logic             tx_off;
    logic             done;
    logic             hit_ovf;
    logic [3:0]       eq_result;

    logic [63:0]      prof = '0;
    logic             force_hit = 1'b0;
    int               win_k = 0;
    logic             window;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    aeq_sweep_seq u_aeq_sweep_seq (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_start_sel(cfg_start_sel),
        .cfg_pat_sel(cfg_pat_sel), .cfg_upper(cfg_upper), .cfg_zero_only(cfg_zero_only),
        .cfg_ofs_code(cfg_ofs_code), .cfg_ofs_neg(cfg_ofs_neg), .cfg_tx_hold(cfg_tx_hold),
        .cfg_settle(cfg_settle), .cfg_dwell(cfg_dwell), .sig_det(sig_det),
        .train_flag(train_flag), .pat_code(pat_code), .rate_change(rate_change),
        .pat_read(pat_read), .hit_inc(hit_inc), .eq_setting(eq_setting),
        .settle_done(settle_done), .tx_off(tx_off), .done(done), .hit_ovf(hit_ovf),
        .eq_result(eq_result)
    );

    // Hit source: during a counting window emit prof[setting] hits, then stay quiet.
    assign window  = settle_done && !done;
    assign hit_inc = force_hit || (window && (win_k < int'(prof[eq_setting*4 +: 4])));

    always @(posedge clk)
        win_k <= window ? win_k + 1 : 0;

    typedef struct packed {
        logic [3:0]  upper;
        logic        zero_only;
        logic [2:0]  code;
        logic        neg;
        logic [63:0] prof;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 1'b0, 3'd2, 1'b0, 64'h0000_0000_0900_1234},
        '{4'hF, 1'b0, 3'd2, 1'b1, 64'h0000_0000_0900_1234},
        '{4'hF, 1'b0, 3'd7, 1'b0, 64'h00E0_0000_0000_0003},
        '{4'h4, 1'b0, 3'd1, 1'b0, 64'h0000_00F0_0005_0500},
        '{4'hF, 1'b1, 3'd3, 1'b0, 64'h0000_0000_0900_1234},
        '{4'hF, 1'b0, 3'd5, 1'b0, 64'h0000_0000_0000_0000},
        '{4'h0, 1'b0, 3'd4, 1'b0, 64'h0000_0000_0000_0007}
    };

    task automatic check(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result from R6, R7, R8.
    function automatic int model_result(input vec_t v, input int dwell);
        int best = 0;
        int best_n = 0;
        int n;
        int r;
        if (v.zero_only)
            return 0;
        for (int s = 0; s <= int'(v.upper); s++) begin
            n = int'(v.prof[s*4 +: 4]);
            if (n > dwell + 1) n = dwell + 1;
            if (n > best_n) begin
                best_n = n;
                best = s;
            end
        end
        r = best + (v.neg ? int'(v.code) - 8 : int'(v.code));
        if (r < 0) r = 0;
        if (r > 15) r = 15;
        return r;
    endfunction

    // Observe whether a pass begins within a few cycles; if so let it finish.
    task automatic try_start(input int exp_start, input string req);
        int seen = 0;
        cfg_enable = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (!done) seen = 1;
        end
        check(seen, exp_start, req);
        if (seen != 0) begin
            for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        end
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_rate(input logic with_read);
        rate_change = 1'b1;
        pat_read    = with_read;
        @(negedge clk);
        rate_change = 1'b0;
        pat_read    = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        int steps = 0;
        vec_t v;
        v = VECS[i];
        cfg_upper     = v.upper;
        cfg_zero_only = v.zero_only;
        cfg_ofs_code  = v.code;
        cfg_ofs_neg   = v.neg;
        prof          = v.prof;
        cfg_tx_hold   = (i % 2 == 0);
        cfg_enable    = 1'b1;
        @(negedge clk);
        check(int'(done), 0, "R9 run started");
        check(int'(settle_done), 0, "R4 settling first");
        check(int'(tx_off), int'(cfg_tx_hold), "R10 tx hold");
        while (!done && steps < 20000) begin
            @(negedge clk);
            steps++;
        end
        check(int'(eq_result), model_result(v, int'(cfg_dwell)), "R6/R7 result");
        if (v.zero_only)
            check(int'(eq_result), 0, "R8 zero only");
        check(int'(tx_off), 0, "R10 released");
        repeat (8) @(negedge clk);
        check(int'(done), 1, "R9 no rerun while enabled");
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset values
        check(int'(done), 1, "R11 done");
        check(int'(hit_ovf), 0, "R11 ovf");
        check(int'(eq_result), 0, "R11 result");
        check(int'(eq_setting), 0, "R11 setting");
        check(int'(settle_done), 0, "R11 settle");
        check(int'(tx_off), 0, "R11 tx_off");

        for (int i = 0; i < NV; i++) run_vec(i);

        // R4: a short pass timed from the start edge
        cfg_upper = 4'h1; cfg_zero_only = 1'b0; cfg_enable = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check(int'(settle_done), 0, "R4 settle last cycle");
        @(negedge clk);
        check(int'(settle_done), 1, "R4 counting begins");
        repeat (16) @(negedge clk);
        check(int'(eq_setting), 1, "R4 next setting");
        check(int'(settle_done), 0, "R4 settle again");
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);

        // R1 start gating
        cfg_start_sel = 1'b1; train_flag = 1'b1;
        try_start(0, "R1 flag blocks");
        cfg_start_sel = 1'b0;
        try_start(1, "R1 flag ignored");
        train_flag = 1'b0; sig_det = 1'b0;
        try_start(0, "R1 no signal");
        sig_det = 1'b1;

        // R2 pattern filter
        cfg_pat_sel = 2'b10; pat_code = 4'd0;
        try_start(1, "R2 pattern 0 loose");
        cfg_pat_sel = 2'b11;
        try_start(0, "R2 pattern 0 strict");
        pat_code = 4'd9; cfg_pat_sel = 2'b10;
        try_start(0, "R2 pattern 9");
        pat_code = 4'd8; cfg_pat_sel = 2'b11;
        try_start(1, "R2 pattern 8 strict");

        // R3 read after rate change
        cfg_pat_sel = 2'b00; pat_code = 4'd6;
        pulse_rate(1'b0);
        try_start(0, "R3 read needed");
        pulse_rate(1'b1);
        try_start(0, "R3 rate beats read");
        pat_read = 1'b1; @(negedge clk); pat_read = 1'b0;
        try_start(1, "R3 read rearms");
        cfg_pat_sel = 2'b10;
        pulse_rate(1'b0);
        try_start(1, "R3 read skipped");

        // R5 overflow, then cleared at the next start
        cfg_upper = 4'h0; cfg_dwell = 16'd9000; force_hit = 1'b1; cfg_enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 12000 && !done; i++) @(negedge clk);
        check(int'(hit_ovf), 1, "R5 overflow set");
        cfg_enable = 1'b0; force_hit = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(hit_ovf), 1, "R5 overflow sticky");
        cfg_dwell = 16'd15; cfg_enable = 1'b1;
        @(negedge clk);
        check(int'(hit_ovf), 0, "R5 cleared on start");
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule